// File: doc/BRIEF.md
# Multi-Mode 8-bit PWM Timer

An up/down counter, parameterised in width, with two compare channels (A and B) and a waveform generator. A 3-bit mode input chooses one of four behaviours: plain free-running counting, clear-on-compare, single-slope (fast) PWM, or dual-slope (phase-correct) PWM. In the two PWM behaviours, TOP is either all ones or the active value of compare channel A. The counter moves only on clock cycles where the `tick` input is high, so an external prescaler sets the rate.

Software reaches the block through one write port with four addresses. Each compare channel keeps a write buffer and an active value. Writes reach the active value at once in the non-PWM modes. In PWM modes they wait for the tick that leaves TOP. Each channel has a 2-bit output-action field and a force strobe. The block raises sticky match flags and an overflow flag, and a write of one clears each flag. Two mode codes are reserved and freeze the counter and the outputs.

Top module: `octpwm_timer`

## Requirements
- R1: After reset the count, both waveform pins, all three flags and the control readback are zero.
- R2: The count changes only on cycles with `tick` high. In mode 0 it counts up from 0xFF to 0x00, and the tick taken at 0xFF sets `ovf_flag`. A write to address 3 with bit 0 set clears `ovf_flag`.
- R3: In mode 2, the tick taken while the count equals the active compare A value returns the count to 0. The overflow flag sets only on a tick at 0xFF.
- R4: Modes 3 and 7 count up and wrap to 0 on the tick taken at TOP. TOP is 0xFF in mode 3 and compare A in mode 7. With action 10 the pin is set on the wrap tick and cleared on the match tick. Action 11 inverts this. If both happen on one tick, the wrap action wins. Overflow sets on the tick at 0xFF in mode 3 and on the tick at TOP in mode 7.
- R5: Modes 1 and 5 count up to TOP, then down to 0, then up again. TOP is 0xFF in mode 1 and compare A in mode 5. With action 10 a match while counting up clears the pin and a match while counting down sets it; action 11 inverts this. Overflow sets on the tick taken at 0 while counting down.
- R6: Address 0 writes compare A and address 1 writes compare B. In modes 0, 2, 4 and 6 the written value is active from the next cycle. In modes 1, 3, 5 and 7 it is held in a buffer and becomes active on the tick that leaves TOP.
- R7: A channel's match flag sets on a tick taken while the count equals that channel's active compare value. The flag stays set until a write to address 3 with bit 1 (A) or bit 2 (B) set clears it. If a set and a clear land in the same cycle, the set wins.
- R8: Address 2 holds the action fields: bits 5:4 for A and bits 3:2 for B. In modes 0 and 2 a match applies action 01 toggle, 10 clear or 11 set. Action 00 drives the pin low while the internal level is held.
- R9: A one in bit 7 (A) or bit 6 (B) of a write to address 2 applies that channel's action immediately in modes 0 and 2. The action used is the one written in the same write. A forced action sets no flag and does not move the counter. The strobe is ignored in PWM and reserved modes, and bits 7:6 of `ctrl_rdata` always read zero.
- R10: In modes 4 and 6 the count, both waveform levels and all flags hold regardless of `tick` and force strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick | input | 1 | Count enable, one cycle per counter step |
| mode | input | 3 | Waveform mode select |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (0 cmp A, 1 cmp B, 2 control, 3 flag clear) |
| wr_data | input | W | Register write data |
| wave_a | output | 1 | Channel A waveform pin |
| wave_b | output | 1 | Channel B waveform pin |
| match_a_flag | output | 1 | Sticky compare A match flag |
| match_b_flag | output | 1 | Sticky compare B match flag |
| ovf_flag | output | 1 | Sticky overflow flag |
| count_o | output | W | Current counter value |
| ctrl_rdata | output | 8 | Control readback, force bits zero |

## Verification
The hardest state to reach from the ports is a buffered compare update in a PWM mode. It can only be seen after a full counter period, at the point where the old compare value still decides matches. To get there, the stimulus first loads both compare values in an immediate mode. It then switches to fast PWM, writes a new value for channel B, and checks that the old value still sets the flag. Finally it runs through TOP and checks that the new value matches on the next period. The phase-correct turn-around is reached by driving the counter through a full up/down cycle. The same-cycle set/clear race on a flag is reached by putting a tick and a flag-clear write on the same edge.

// File: rtl/octpwm_pkg.sv
package octpwm_pkg;

  typedef enum logic [1:0] {
    COM_OFF    = 2'b00,
    COM_TOGGLE = 2'b01,
    COM_CLEAR  = 2'b10,
    COM_SET    = 2'b11
  } com_e;

  typedef struct packed {
    logic run;
    logic pwm;
    logic dual_slope;
    logic top_is_a;
    logic ovf_at_top;
    logic ovf_at_bottom;
  } mode_cfg_t;

  localparam logic [1:0] REG_CMP_A = 2'd0;
  localparam logic [1:0] REG_CMP_B = 2'd1;
  localparam logic [1:0] REG_CTRL  = 2'd2;
  localparam logic [1:0] REG_FLAGS = 2'd3;

  function automatic mode_cfg_t decode_mode(input logic [2:0] m);
    mode_cfg_t c;
    c = '0;
    case (m)
      3'd0: c.run = 1'b1;
      3'd1: begin
        c.run = 1'b1; c.pwm = 1'b1; c.dual_slope = 1'b1; c.ovf_at_bottom = 1'b1;
      end
      3'd2: begin
        c.run = 1'b1; c.top_is_a = 1'b1;
      end
      3'd3: begin
        c.run = 1'b1; c.pwm = 1'b1;
      end
      3'd5: begin
        c.run = 1'b1; c.pwm = 1'b1; c.dual_slope = 1'b1;
        c.top_is_a = 1'b1; c.ovf_at_bottom = 1'b1;
      end
      3'd7: begin
        c.run = 1'b1; c.pwm = 1'b1; c.top_is_a = 1'b1; c.ovf_at_top = 1'b1;
      end
      default: c = '0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/octpwm_counter.sv
module octpwm_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         run,
  input  logic         dual_slope,
  input  logic         ovf_at_top,
  input  logic         ovf_at_bottom,
  input  logic [W-1:0] top,
  output logic [W-1:0] count,
  output logic         down,
  output logic         step,
  output logic         top_evt,
  output logic         ovf_evt
);

  localparam logic [W-1:0] MAXV = '1;
  localparam logic [W-1:0] ONE  = W'(1);

  logic [W-1:0] count_q, count_d;
  logic         down_q, down_d;
  logic         at_top, ovf_hit;

  // next-state
  always_comb begin
    step    = tick & run;
    at_top  = dual_slope ? (!down_q && (count_q >= top)) : (count_q == top);
    top_evt = step & at_top;

    if (ovf_at_bottom)   ovf_hit = down_q && (count_q == '0);
    else if (ovf_at_top) ovf_hit = (count_q == top);
    else                 ovf_hit = (count_q == MAXV);
    ovf_evt = step & ovf_hit;

    count_d = count_q;
    down_d  = down_q;
    if (step) begin
      if (dual_slope) begin
        if (top == '0) begin
          count_d = '0;
          down_d  = 1'b0;
        end else if (!down_q) begin
          if (count_q >= top) begin
            count_d = count_q - ONE;
            down_d  = 1'b1;
          end else begin
            count_d = count_q + ONE;
          end
        end else if (count_q == '0) begin
          count_d = ONE;
          down_d  = 1'b0;
        end else begin
          count_d = count_q - ONE;
        end
      end else begin
        count_d = at_top ? '0 : (count_q + ONE);
        down_d  = 1'b0;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      down_q  <= 1'b0;
    end else begin
      count_q <= count_d;
      down_q  <= down_d;
    end
  end

  assign count = count_q;
  assign down  = down_q;

endmodule

// File: rtl/octpwm_chan.sv
module octpwm_chan
  import octpwm_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         pwm,
  input  logic         dual_slope,
  input  logic         step,
  input  logic         top_evt,
  input  logic         down,
  input  logic [W-1:0] count,
  input  logic [1:0]   com,
  input  logic         force_stb,
  input  logic         wr_stb,
  input  logic [W-1:0] wr_val,
  output logic [W-1:0] ocr,
  output logic         level,
  output logic         match_evt
);

  logic [W-1:0] ocr_q, ocr_d, buf_q, buf_d;
  logic         lvl_q, lvl_d;
  logic         pwm_act;

  // next-state
  always_comb begin
    match_evt = step & (count == ocr_q);
    pwm_act   = (com == COM_CLEAR) || (com == COM_SET);

    buf_d = wr_stb ? wr_val : buf_q;
    ocr_d = ocr_q;
    if (wr_stb && !pwm)      ocr_d = wr_val;
    else if (pwm && top_evt) ocr_d = buf_q;

    lvl_d = lvl_q;
    if (!pwm) begin
      if (run && (match_evt || force_stb)) begin
        case (com)
          COM_TOGGLE: lvl_d = ~lvl_q;
          COM_CLEAR:  lvl_d = 1'b0;
          COM_SET:    lvl_d = 1'b1;
          default:    lvl_d = lvl_q;
        endcase
      end
    end else if (!dual_slope) begin
      if (top_evt && pwm_act)        lvl_d = (com == COM_CLEAR);
      else if (match_evt && pwm_act) lvl_d = (com == COM_SET);
    end else if (match_evt && pwm_act) begin
      lvl_d = down ? (com == COM_CLEAR) : (com == COM_SET);
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ocr_q <= '0;
      buf_q <= '0;
      lvl_q <= 1'b0;
    end else begin
      ocr_q <= ocr_d;
      buf_q <= buf_d;
      lvl_q <= lvl_d;
    end
  end

  assign ocr   = ocr_q;
  assign level = lvl_q;

endmodule

// File: rtl/octpwm_timer.sv
// W must be at least 8: control and flag-clear fields sit in the low byte.
module octpwm_timer
  import octpwm_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [2:0]   mode,
  input  logic         wr_en,
  input  logic [1:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  output logic         wave_a,
  output logic         wave_b,
  output logic         match_a_flag,
  output logic         match_b_flag,
  output logic         ovf_flag,
  output logic [W-1:0] count_o,
  output logic [7:0]   ctrl_rdata
);

  localparam int      NCH  = 2;
  localparam logic [W-1:0] MAXV = '1;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  mode_cfg_t cfg;
  assign cfg = decode_mode(mode);

  logic ctrl_wr, flag_wr;
  assign ctrl_wr = wr_en && (wr_addr == REG_CTRL);
  assign flag_wr = wr_en && (wr_addr == REG_FLAGS);

  logic [W-1:0] top_val, cmp_a_act;
  logic [W-1:0] count;
  logic         down, step, top_evt, ovf_evt;

  logic [NCH-1:0][1:0]   com_q, com_d;
  logic [NCH-1:0][W-1:0] ocr;
  logic [NCH-1:0]        lvl, match_evt, force_stb, cmp_wr;
  logic [NCH-1:0]        mflag_q, mflag_d;
  logic                  ovf_q, ovf_d;

  assign cmp_a_act = ocr[0];
  assign top_val   = cfg.top_is_a ? cmp_a_act : MAXV;

  octpwm_counter #(.W(W)) cnt_i (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .tick          (tick),
    .run           (cfg.run),
    .dual_slope    (cfg.dual_slope),
    .ovf_at_top    (cfg.ovf_at_top),
    .ovf_at_bottom (cfg.ovf_at_bottom),
    .top           (top_val),
    .count         (count),
    .down          (down),
    .step          (step),
    .top_evt       (top_evt),
    .ovf_evt       (ovf_evt)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    localparam int COM_HI = 5 - 2 * ch;

    assign com_d[ch]     = ctrl_wr ? wr_data[COM_HI -: 2] : com_q[ch];
    assign force_stb[ch] = ctrl_wr && wr_data[7 - ch];
    assign cmp_wr[ch]    = wr_en && (wr_addr == 2'(ch));
    assign mflag_d[ch]   = match_evt[ch] | (mflag_q[ch] & ~(flag_wr & wr_data[ch + 1]));

    octpwm_chan #(.W(W)) chan_i (
      .clk        (clk),
      .rst_n      (rst_sync_n),
      .run        (cfg.run),
      .pwm        (cfg.pwm),
      .dual_slope (cfg.dual_slope),
      .step       (step),
      .top_evt    (top_evt),
      .down       (down),
      .count      (count),
      .com        (com_d[ch]),
      .force_stb  (force_stb[ch]),
      .wr_stb     (cmp_wr[ch]),
      .wr_val     (wr_data),
      .ocr        (ocr[ch]),
      .level      (lvl[ch]),
      .match_evt  (match_evt[ch])
    );
  end

  assign ovf_d = ovf_evt | (ovf_q & ~(flag_wr & wr_data[0]));

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      com_q   <= '0;
      mflag_q <= '0;
      ovf_q   <= 1'b0;
    end else begin
      com_q   <= com_d;
      mflag_q <= mflag_d;
      ovf_q   <= ovf_d;
    end
  end

  assign wave_a       = (com_q[0] != COM_OFF) & lvl[0];
  assign wave_b       = (com_q[1] != COM_OFF) & lvl[1];
  assign match_a_flag = mflag_q[0];
  assign match_b_flag = mflag_q[1];
  assign ovf_flag     = ovf_q;
  assign count_o      = count;
  assign ctrl_rdata   = {2'b00, com_q[0], com_q[1], 2'b00};

endmodule

// File: rtl/octpwm_timer_chk.sv
module octpwm_timer_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick,
  input logic [2:0]   mode,
  input logic         wr_en,
  input logic [1:0]   wr_addr,
  input logic [W-1:0] wr_data,
  input logic [W-1:0] count,
  input logic [W-1:0] cmp_a,
  input logic         wave_a,
  input logic         wave_b,
  input logic         match_a_flag,
  input logic         ovf_flag,
  input logic [7:0]   ctrl_rdata
);

  p_hold_no_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> (count == $past(count)));

  p_normal_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd0 && tick && count == '1) |=> (count == '0 && ovf_flag));

  p_ctc_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd2 && tick && count == cmp_a) |=> (count == '0));

  p_sticky_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (match_a_flag && !(wr_en && wr_addr == 2'd3 && wr_data[1])) |=> match_a_flag);

  p_force_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd2 && wr_data[7] && !tick && !match_a_flag) |=> !match_a_flag);

  p_force_pwm_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[0] && wr_en && wr_addr == 2'd2 && wr_data[5:4] == ctrl_rdata[5:4] && !tick)
      |=> $stable(wave_a));

  p_reserved_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == 3'd4 || mode == 3'd6) && !wr_en)
      |=> ($stable(count) && $stable(wave_a) && $stable(wave_b) && !$rose(ovf_flag)));

endmodule

bind octpwm_timer octpwm_timer_chk #(.W(W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .tick         (tick),
  .mode         (mode),
  .wr_en        (wr_en),
  .wr_addr      (wr_addr),
  .wr_data      (wr_data),
  .count        (count_o),
  .cmp_a        (cmp_a_act),
  .wave_a       (wave_a),
  .wave_b       (wave_b),
  .match_a_flag (match_a_flag),
  .ovf_flag     (ovf_flag),
  .ctrl_rdata   (ctrl_rdata)
);

// File: tb/octpwm_timer_tb_top.sv
module octpwm_timer_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick;
  logic [2:0] mode;
  logic       wr_en;
  logic [1:0] wr_addr;
  logic [7:0] wr_data;
  logic       wave_a, wave_b, match_a_flag, match_b_flag, ovf_flag;
  logic [7:0] count_o, ctrl_rdata;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  octpwm_timer #(.W(8)) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick         (tick),
    .mode         (mode),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .wave_a       (wave_a),
    .wave_b       (wave_b),
    .match_a_flag (match_a_flag),
    .match_b_flag (match_b_flag),
    .ovf_flag     (ovf_flag),
    .count_o      (count_o),
    .ctrl_rdata   (ctrl_rdata)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input logic [2:0] m);
    mode = m; tick = 1'b0; wr_en = 1'b0; wr_addr = 2'd0; wr_data = 8'h00;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = 8'h00;
  endtask

  task automatic run(input int n);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    do_reset(3'd0);
    chk("R1", "count", count_o, 0);
    chk("R1", "wave_a", wave_a, 0);
    chk("R1", "wave_b", wave_b, 0);
    chk("R1", "flags", {match_a_flag, match_b_flag, ovf_flag}, 0);
    chk("R1", "ctrl", ctrl_rdata, 0);
  endtask

  task automatic t_normal;
    do_reset(3'd0);
    idle(3);
    chk("R2", "count without tick", count_o, 0);
    run(5);
    chk("R2", "count after 5", count_o, 5);
    run(250);
    chk("R2", "count at max", count_o, 8'hFF);
    chk("R2", "ovf before wrap", ovf_flag, 0);
    run(1);
    chk("R2", "count wrapped", count_o, 0);
    chk("R2", "ovf after wrap", ovf_flag, 1);
    wr(2'd3, 8'h01);
    chk("R2", "ovf cleared", ovf_flag, 0);
  endtask

  task automatic t_ctc;
    do_reset(3'd2);
    wr(2'd0, 8'd9);
    wr(2'd2, 8'h10);
    run(9);
    chk("R3", "count before compare", count_o, 9);
    chk("R3", "match_a before", match_a_flag, 0);
    chk("R8", "wave_a before toggle", wave_a, 0);
    run(1);
    chk("R3", "count cleared", count_o, 0);
    chk("R7", "match_a set", match_a_flag, 1);
    chk("R8", "wave_a toggled high", wave_a, 1);
    chk("R3", "no ovf below max", ovf_flag, 0);
    run(10);
    chk("R3", "count after period", count_o, 0);
    chk("R8", "wave_a toggled low", wave_a, 0);
  endtask

  task automatic t_fast;
    do_reset(3'd0);
    wr(2'd0, 8'd9);
    wr(2'd1, 8'd3);
    wr(2'd2, 8'h08);
    mode = 3'd7;
    run(10);
    chk("R4", "mode7 wrap", count_o, 0);
    chk("R4", "wave_b set at bottom", wave_b, 1);
    chk("R4", "mode7 ovf at top", ovf_flag, 1);
    run(3);
    chk("R4", "wave_b before match", wave_b, 1);
    run(1);
    chk("R4", "count after match", count_o, 4);
    chk("R4", "wave_b cleared", wave_b, 0);
    wr(2'd2, 8'h0C);
    run(6);
    chk("R4", "inverted bottom", wave_b, 0);
    run(4);
    chk("R4", "inverted match", wave_b, 1);
    do_reset(3'd3);
    run(255);
    chk("R4", "mode3 count max", count_o, 8'hFF);
    chk("R4", "mode3 no ovf yet", ovf_flag, 0);
    run(1);
    chk("R4", "mode3 wrap", count_o, 0);
    chk("R4", "mode3 ovf", ovf_flag, 1);
  endtask

  task automatic t_phase;
    do_reset(3'd0);
    wr(2'd0, 8'd4);
    wr(2'd1, 8'd2);
    wr(2'd2, 8'h08);
    mode = 3'd5;
    run(6);
    chk("R5", "count after turn", count_o, 2);
    run(1);
    chk("R5", "down count", count_o, 1);
    chk("R5", "wave_b set on down match", wave_b, 1);
    run(1);
    chk("R5", "reach bottom", count_o, 0);
    chk("R5", "no ovf yet", ovf_flag, 0);
    run(1);
    chk("R5", "turn up", count_o, 1);
    chk("R5", "ovf at bottom", ovf_flag, 1);
    run(2);
    chk("R5", "up count", count_o, 3);
    chk("R5", "wave_b cleared on up match", wave_b, 0);
  endtask

  task automatic t_buffer;
    do_reset(3'd0);
    run(1);
    wr(2'd3, 8'h06);
    wr(2'd1, 8'd3);
    run(3);
    chk("R6", "immediate compare", match_b_flag, 1);
    do_reset(3'd0);
    wr(2'd0, 8'd9);
    wr(2'd1, 8'd5);
    mode = 3'd3;
    wr(2'd1, 8'd7);
    run(6);
    chk("R6", "old compare active", match_b_flag, 1);
    wr(2'd3, 8'h04);
    run(2);
    chk("R6", "count", count_o, 8);
    chk("R6", "new value not yet active", match_b_flag, 0);
    run(248);
    chk("R6", "wrapped", count_o, 0);
    chk("R6", "still no match", match_b_flag, 0);
    run(8);
    chk("R6", "new compare active", match_b_flag, 1);
  endtask

  task automatic t_flags;
    do_reset(3'd0);
    run(1);
    chk("R7", "match_a set", match_a_flag, 1);
    idle(5);
    chk("R7", "match_a sticky", match_a_flag, 1);
    wr(2'd3, 8'h02);
    chk("R7", "match_a cleared", match_a_flag, 0);
    wr(2'd0, 8'd3);
    run(2);
    chk("R7", "no match yet", match_a_flag, 0);
    tick = 1'b1; wr_en = 1'b1; wr_addr = 2'd3; wr_data = 8'h02;
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0; wr_data = 8'h00;
    chk("R7", "set wins over clear", match_a_flag, 1);
    chk("R7", "count", count_o, 4);
  endtask

  task automatic t_force;
    do_reset(3'd2);
    wr(2'd0, 8'd20);
    run(3);
    wr(2'd3, 8'h07);
    wr(2'd2, 8'hB0);
    chk("R9", "forced set", wave_a, 1);
    chk("R9", "count untouched", count_o, 3);
    chk("R9", "no flag", match_a_flag, 0);
    chk("R9", "force reads zero", ctrl_rdata, 8'h30);
    wr(2'd2, 8'h00);
    chk("R8", "disconnected low", wave_a, 0);
    wr(2'd2, 8'h30);
    chk("R8", "level held", wave_a, 1);
    wr(2'd2, 8'hA0);
    chk("R8", "forced clear", wave_a, 0);
    wr(2'd2, 8'h90);
    chk("R8", "forced toggle", wave_a, 1);
    mode = 3'd3;
    wr(2'd2, 8'h20);
    chk("R9", "pwm level", wave_a, 1);
    wr(2'd2, 8'hA0);
    chk("R9", "force ignored in pwm", wave_a, 1);
    chk("R9", "count in pwm", count_o, 3);
  endtask

  task automatic t_reserved;
    do_reset(3'd0);
    wr(2'd0, 8'd2);
    wr(2'd2, 8'h10);
    run(3);
    chk("R10", "setup wave", wave_a, 1);
    wr(2'd3, 8'h07);
    mode = 3'd4;
    run(10);
    chk("R10", "count held", count_o, 3);
    chk("R10", "wave held", wave_a, 1);
    chk("R10", "no flags", {match_a_flag, ovf_flag}, 0);
    wr(2'd2, 8'h90);
    chk("R10", "force ignored", wave_a, 1);
    mode = 3'd6;
    run(5);
    chk("R10", "mode6 count held", count_o, 3);
  endtask

  initial begin
    rst_n = 1'b0; tick = 1'b0; mode = 3'd0;
    wr_en = 1'b0; wr_addr = 2'd0; wr_data = 8'h00;
    t_reset();
    t_normal();
    t_ctc();
    t_fast();
    t_phase();
    t_buffer();
    t_flags();
    t_force();
    t_reserved();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule